// File: doc/BRIEF.md
# Trigger Source Selector with Edge Detect

This block turns one of eight event flags into a request to start a conversion. A 3-bit select field in an 8-bit control register picks which flag is watched. The selected flag is sampled on every clock. When it goes from low to high, the block issues a start pulse that lasts one clock. The pulse is only issued while both the auto-trigger enable and the converter enable are high.

Edge detection is done on the output of the source multiplexer, not on each source separately. Because of this, rewriting the select field from a low source to a high source also counts as a rising edge and fires a start. While auto-triggering is disabled, the detector keeps its stored sample in step with the selected flag. A flag that is already high when triggering is enabled therefore does not fire. The control register also holds one spare read/write control bit. All other bits are reserved and always read back as zero.

Top module: `autotrig_select`

## Requirements
- R1: While reset is held and after it is released, `bus_rdata` reads 0x00 and `conv_start` is 0. The select field resets to 0.
- R2: A cycle with `bus_we` high stores `bus_wdata[2:0]` as the source select and `bus_wdata[6]` as the spare control bit. Both are visible on `bus_rdata` at the same bit positions from the clock edge that takes the write.
- R3: Bits 7, 5, 4 and 3 of `bus_rdata` are always 0, whatever value was written to them.
- R4: With both enables high, a low-to-high change of the selected flag gives `conv_start` high for exactly the one cycle after the clock edge that first samples the flag high.
- R5: Changes on flags that are not selected never produce `conv_start`.
- R6: With `atrig_en` low, no edge produces `conv_start`. A selected flag that is already high when `atrig_en` is raised does not fire.
- R7: An edge seen while `conv_en` is low is dropped. Raising `conv_en` later, while the flag stays high, does not fire.
- R8: Rewriting the select field from a low flag to a high flag, with both enables high, gives one `conv_start` in the cycle after the edge that follows the write edge.
- R9: A selected flag held high produces only one pulse.
- R10: A falling edge of the selected flag, and a switch from a high flag to a low flag, produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 8 | Candidate trigger flags, index equals select code |
| atrig_en | input | 1 | Auto-trigger enable |
| conv_en | input | 1 | Converter enable; pulses are dropped while low |
| bus_we | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Control register write data |
| bus_rdata | output | 8 | Control register read value |
| conv_start | output | 1 | One-cycle conversion start |

## Verification
A flag edge driven before a clock edge is due on `conv_start` right after that clock edge, one register stage later. A select rewrite is due one edge later than that, because the select register adds a stage. Register readback is due immediately after the write edge. Inputs are driven on falling edges, and the driver records each expected pulse in a scoreboard queue keyed by the cycle count. A monitor samples `conv_start` on each falling edge and matches it against the head of the queue. It reports early, late, missing and unexpected pulses, naming the requirement of the phase in which each occurs.

// File: rtl/atrig_pkg.sv
package atrig_pkg;

    localparam int NUM_SRC  = 8;
    localparam int SEL_W    = $clog2(NUM_SRC);
    localparam int REG_W    = 8;
    localparam int SEL_LSB  = 0;
    localparam int AUX_POS  = 6;

    typedef logic [SEL_W-1:0] src_sel_t;
    typedef logic [REG_W-1:0] reg_word_t;

    typedef struct packed {
        logic     aux;
        src_sel_t sel;
    } cfg_t;

    function automatic reg_word_t cfg_to_word(cfg_t c);
        reg_word_t w;
        w = '0;
        w[SEL_LSB +: SEL_W] = c.sel;
        w[AUX_POS]          = c.aux;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(reg_word_t w);
        cfg_t c;
        c.sel = w[SEL_LSB +: SEL_W];
        c.aux = w[AUX_POS];
        return c;
    endfunction

endpackage

// File: rtl/atrig_cfg_reg.sv
module atrig_cfg_reg
    import atrig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  reg_word_t wr_data,
    output cfg_t      cfg,
    output reg_word_t rd_data
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= word_to_cfg(wr_data);
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = cfg_to_word(cfg_q);

    a_r2_sel_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[SEL_LSB +: SEL_W] == $past(wr_data[SEL_LSB +: SEL_W]));

    a_r2_aux_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[AUX_POS] == $past(wr_data[AUX_POS]));

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/atrig_src_mux.sv
module atrig_src_mux #(
    parameter int N = atrig_pkg::NUM_SRC,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  src,
    input  logic [SW-1:0] sel,
    output logic          picked
);

    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign hit[g] = src[g] & (sel == SW'(g));
    end

    assign picked = |hit;

endmodule

// File: rtl/atrig_edge.sv
module atrig_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic arm,
    input  logic allow,
    output logic pulse
);

    logic prev_q;
    logic pulse_q;

    // prev_q follows the input every cycle, armed or not, so a level that is
    // already high when arming is not mistaken for a fresh edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= sig_in;
            pulse_q <= sig_in & ~prev_q & arm & allow;
        end
    end

    assign pulse = pulse_q;

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    a_r6_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(arm));

    a_r7_needs_allow: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(allow));

    a_r10_high_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(sig_in));

endmodule

// File: rtl/autotrig_select.sv
module autotrig_select
    import atrig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic               atrig_en,
    input  logic               conv_en,
    input  logic               bus_we,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               conv_start
);

    cfg_t cfg;
    logic picked;

    atrig_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .wr_data (bus_wdata),
        .cfg     (cfg),
        .rd_data (bus_rdata)
    );

    atrig_src_mux #(.N(NUM_SRC)) u_mux (
        .src    (src_flag),
        .sel    (cfg.sel),
        .picked (picked)
    );

    atrig_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (picked),
        .arm    (atrig_en),
        .allow  (conv_en),
        .pulse  (conv_start)
    );

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7] == 1'b0 && bus_rdata[5:3] == 3'b000);

    a_r1_reset_start_low: assert property (@(posedge clk)
        $past(rst) |-> !conv_start);

endmodule

// File: tb/autotrig_select_tb.sv
module autotrig_select_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_flag = '0;
    logic       atrig_en = 1'b0;
    logic       conv_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_start;

    int    cyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    typedef struct {
        int    at;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    autotrig_select u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_flag   (src_flag),
        .atrig_en   (atrig_en),
        .conv_en    (conv_en),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .conv_start (conv_start)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_pulse(int at, string req);
        exp_t e;
        e.at  = at;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic wr(logic [7:0] d);
        bus_we    = 1'b1;
        bus_wdata = d;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic check_rd(logic [7:0] exp, string req);
        nchk++;
        if (bus_rdata !== exp) begin
            nfail++;
            $display("FAIL %s: bus_rdata actual %02h expected %02h", req, bus_rdata, exp);
        end
    endtask

    // Monitor: compares each falling-edge sample against the scoreboard head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (conv_start === 1'b1) begin
                nchk++;
                if (sb.size() > 0 && sb[0].at == cyc) begin
                    void'(sb.pop_front());
                end else begin
                    nfail++;
                    $display("FAIL %s: conv_start actual 1 expected 0 at cycle %0d", phase, cyc);
                end
            end else if (sb.size() > 0 && sb[0].at <= cyc) begin
                nchk++;
                nfail++;
                $display("FAIL %s: conv_start actual %b expected 1 at cycle %0d",
                         sb[0].req, conv_start, sb[0].at);
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(3);
        check_rd(8'h00, "R1");
        nchk++;
        if (conv_start !== 1'b0) begin
            nfail++;
            $display("FAIL R1: conv_start actual %b expected 0", conv_start);
        end
        rst = 1'b0;
        step();
        check_rd(8'h00, "R1");
        mon_on = 1'b1;

        // R2 / R3: register fields and reserved bits
        phase = "R2";
        wr(8'h47);  check_rd(8'h47, "R2");
        wr(8'h05);  check_rd(8'h05, "R2");
        phase = "R3";
        wr(8'hFF);  check_rd(8'h47, "R3");
        wr(8'hB8);  check_rd(8'h00, "R3");

        // R4: basic rising edge on source 2
        phase = "R4";
        atrig_en = 1'b1;
        conv_en  = 1'b1;
        wr(8'h02);  check_rd(8'h02, "R2");
        step(2);
        src_flag[2] = 1'b1;
        expect_pulse(cyc + 1, "R4");
        step();
        // R9: held high -> no more pulses
        phase = "R9";
        step(5);
        // R10: falling edge -> nothing
        phase = "R10";
        src_flag[2] = 1'b0;
        step(3);
        phase = "R4";
        src_flag[2] = 1'b1;
        expect_pulse(cyc + 1, "R4");
        step(2);
        src_flag[2] = 1'b0;
        step(2);

        // R5: unselected sources ignored
        phase = "R5";
        for (int k = 0; k < 8; k++) begin
            if (k != 2) begin
                src_flag[k] = 1'b1;
                step(2);
                src_flag[k] = 1'b0;
                step();
            end
        end
        step(2);

        // R6: auto-trigger disabled
        phase = "R6";
        atrig_en = 1'b0;
        src_flag[2] = 1'b1;
        step(3);
        atrig_en = 1'b1;
        step(4);
        src_flag[2] = 1'b0;
        step(2);
        phase = "R4";
        src_flag[2] = 1'b1;
        expect_pulse(cyc + 1, "R4");
        step(2);

        // R7: converter disabled
        phase = "R7";
        src_flag[2] = 1'b0;
        step(2);
        conv_en = 1'b0;
        src_flag[2] = 1'b1;
        step(3);
        conv_en = 1'b1;
        step(4);

        // R8: select switch from low source to high source
        phase = "R8";
        src_flag = 8'b0010_0000;   // source 5 high, 2 low
        wr(8'h02);
        step(3);
        expect_pulse(cyc + 2, "R8");
        wr(8'h05);  check_rd(8'h05, "R2");
        step(4);
        // R10: switch from high source to low source
        phase = "R10";
        wr(8'h01);
        step(4);
        phase = "R8";
        expect_pulse(cyc + 2, "R8");
        wr(8'h45);  check_rd(8'h45, "R2");
        step(4);

        nchk++;
        if (sb.size() != 0) begin
            nfail++;
            $display("FAIL R4: pending pulses actual %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule